// File: doc/BRIEF.md
# Two-Level Classifier Tree Sequencer

This block runs a two-stage hierarchical classification on one external network engine. A host presents a feature vector and a start request. The block stores the vector once and starts a first pass on a root network structure that the host chose. The engine's winning output from that pass is the superclass. The block uses the superclass to index a programmable table, which names the leaf network structure for the second pass. It then starts that leaf on the same stored vector, and the leaf's winner becomes the detailed class.

The engine is reached through a small command port. The block sends a 6-bit structure index with a one-cycle start pulse. The engine answers with a one-cycle done pulse and a winner index. The arithmetic of the networks lies outside this block. A table entry can hold a reserved value that ends the run after the root pass. An entry that was never written ends the run with an error flag. A flat mode, chosen per run, skips the table entirely and gives a plain single-network classification.

Top module: `cls_tree_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `eng_start_o` are 0, and every table entry is unconfigured.
- R2: A start request that arrives while the block is idle is accepted. On the next cycle `busy_o` is 1 and `eng_start_o` pulses for one cycle, with `eng_struct_o` equal to the `root_sel_i` value sampled at acceptance.
- R3: A start request that arrives while `busy_o` is 1 is ignored. It issues no extra engine start and does not change the result.
- R4: From acceptance until completion, `eng_vec_o` holds the vector sampled at acceptance, whatever `vec_i` does in the meantime.
- R5: In tree mode, when the root done arrives and the root winner's table entry is configured and is not 63, the leaf start pulse appears on the very next cycle. That pulse carries `eng_struct_o` equal to the table entry.
- R6: One cycle after the leaf done, `done_o` pulses for one cycle with the following values: `super_o` is the root winner, `class_o` is the leaf winner, `leaf_ran_o` is 1 and `err_o` is 0. `busy_o` is 0 in that same cycle.
- R7: A configured entry equal to 63 means "no leaf". `done_o` then pulses one cycle after the root done, with `class_o` equal to the root winner, `leaf_ran_o` equal to 0 and `err_o` equal to 0.
- R8: If the root winner's entry is unconfigured, the run ends after the root pass. `err_o` is 1, `leaf_ran_o` is 0, and no leaf start is issued.
- R9: When `tree_i` is 0 at acceptance, only the root pass runs and the table is not consulted. The result has `err_o` equal to 0, `leaf_ran_o` equal to 0, and `class_o` equal to the root winner.
- R10: An `eng_done_i` pulse is ignored when no pass is outstanding. In that case it produces no `done_o` and leaves `busy_o` unchanged.
- R11: A table write with `map_we_i` set stores `map_leaf_i` at entry `map_addr_i` and marks that entry configured. A later write to the same entry replaces the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request; vector and selections are valid with it |
| tree_i | input | 1 | 1: root then leaf; 0: root pass only |
| root_sel_i | input | IDX_W | Structure index of the root network |
| vec_i | input | N_FEAT*FEAT_W | Input feature vector |
| busy_o | output | 1 | A run is in progress |
| map_we_i | input | 1 | Table write enable |
| map_addr_i | input | IDX_W | Root winner index to program |
| map_leaf_i | input | IDX_W | Leaf structure index; 63 means no leaf |
| eng_start_o | output | 1 | One-cycle pass start to the engine |
| eng_struct_o | output | IDX_W | Structure index for the pass |
| eng_vec_o | output | N_FEAT*FEAT_W | Stored feature vector |
| eng_done_i | input | 1 | Engine pass finished |
| eng_win_i | input | IDX_W | Winning output index, valid with done |
| done_o | output | 1 | One-cycle result strobe |
| super_o | output | IDX_W | Root winner (superclass) |
| class_o | output | IDX_W | Leaf winner, or root winner when no leaf ran |
| leaf_ran_o | output | 1 | A leaf pass contributed the class |
| err_o | output | 1 | Root winner mapped to an unconfigured entry |

## Verification
The hardest situation to reach is the hand-off between passes. The leaf start must follow the root done with no idle cycle, while the host is still trying to start again and `vec_i` is changing. A behavioural engine model in the bench records the cycle of each done it drives and the cycle of each start it sees, so the one-cycle gaps can be measured. The directed runs place a second start request inside a run and overwrite `vec_i` right after acceptance. A spurious done is also driven while the block is idle.

// File: rtl/cls_tree_pkg.sv
package cls_tree_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROOT = 2'd1,
        ST_LEAF = 2'd2
    } seq_st_e;
endpackage

// File: rtl/cls_leaf_map.sv
module cls_leaf_map #(
    parameter int IDX_W = 6,
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] waddr_i,
    input  logic [IDX_W-1:0]         wdata_i,
    input  logic [$clog2(DEPTH)-1:0] raddr_i,
    output logic [IDX_W-1:0]         rdata_o,
    output logic                     rcfg_o
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic             cfg;
        logic [IDX_W-1:0] leaf;
    } ent_t;

    logic [DEPTH-1:0]       cfg_all;
    logic [DEPTH*IDX_W-1:0] leaf_all;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        ent_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we_i && (waddr_i == AW'(g))) begin
                ent_d.cfg  = 1'b1;
                ent_d.leaf = wdata_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign cfg_all[g]                  = ent_q.cfg;
        assign leaf_all[g*IDX_W +: IDX_W]  = ent_q.leaf;
    end

    always_comb begin
        rdata_o = '0;
        rcfg_o  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr_i == AW'(i)) begin
                rdata_o = leaf_all[i*IDX_W +: IDX_W];
                rcfg_o  = cfg_all[i];
            end
        end
    end
endmodule

// File: rtl/cls_vec_buf.sv
module cls_vec_buf #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] data_o
);
    logic [W-1:0] buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (load_i) buf_d = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign data_o = buf_q;
endmodule

// File: rtl/cls_tree_fsm.sv
module cls_tree_fsm
    import cls_tree_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tree_i,
    input  logic [IDX_W-1:0] root_sel_i,
    input  logic             eng_done_i,
    input  logic [IDX_W-1:0] eng_win_i,
    input  logic [IDX_W-1:0] map_leaf_i,
    input  logic             map_cfg_i,
    output logic             load_o,
    output logic             busy_o,
    output logic             eng_start_o,
    output logic [IDX_W-1:0] eng_struct_o,
    output logic             done_o,
    output logic [IDX_W-1:0] super_o,
    output logic [IDX_W-1:0] class_o,
    output logic             leaf_ran_o,
    output logic             err_o
);
    localparam logic [IDX_W-1:0] NO_LEAF = '1;

    typedef struct packed {
        seq_st_e          st;
        logic             start;
        logic [IDX_W-1:0] strc;
        logic             tree;
        logic [IDX_W-1:0] sup;
        logic [IDX_W-1:0] cls;
        logic             leaf;
        logic             err;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;
    logic pass_end;

    // a done in the same cycle as our own start pulse is not ours
    assign pass_end = eng_done_i && !s_q.start;
    assign load_o   = (s_q.st == ST_IDLE) && start_i;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.done  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st    = ST_ROOT;
                    s_d.start = 1'b1;
                    s_d.strc  = root_sel_i;
                    s_d.tree  = tree_i;
                end
            end
            ST_ROOT: begin
                if (pass_end) begin
                    s_d.sup  = eng_win_i;
                    s_d.cls  = eng_win_i;
                    s_d.leaf = 1'b0;
                    s_d.err  = 1'b0;
                    if (!s_q.tree) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end else if (!map_cfg_i) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.err  = 1'b1;
                    end else if (map_leaf_i == NO_LEAF) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st    = ST_LEAF;
                        s_d.start = 1'b1;
                        s_d.strc  = map_leaf_i;
                    end
                end
            end
            ST_LEAF: begin
                if (pass_end) begin
                    s_d.st   = ST_IDLE;
                    s_d.cls  = eng_win_i;
                    s_d.leaf = 1'b1;
                    s_d.err  = 1'b0;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o       = (s_q.st != ST_IDLE);
    assign eng_start_o  = s_q.start;
    assign eng_struct_o = s_q.strc;
    assign done_o       = s_q.done;
    assign super_o      = s_q.sup;
    assign class_o      = s_q.cls;
    assign leaf_ran_o   = s_q.leaf;
    assign err_o        = s_q.err;
endmodule

// File: rtl/cls_tree_seq.sv
module cls_tree_seq #(
    parameter int IDX_W  = 6,
    parameter int N_FEAT = 16,
    parameter int FEAT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     tree_i,
    input  logic [IDX_W-1:0]         root_sel_i,
    input  logic [N_FEAT*FEAT_W-1:0] vec_i,
    output logic                     busy_o,
    input  logic                     map_we_i,
    input  logic [IDX_W-1:0]         map_addr_i,
    input  logic [IDX_W-1:0]         map_leaf_i,
    output logic                     eng_start_o,
    output logic [IDX_W-1:0]         eng_struct_o,
    output logic [N_FEAT*FEAT_W-1:0] eng_vec_o,
    input  logic                     eng_done_i,
    input  logic [IDX_W-1:0]         eng_win_i,
    output logic                     done_o,
    output logic [IDX_W-1:0]         super_o,
    output logic [IDX_W-1:0]         class_o,
    output logic                     leaf_ran_o,
    output logic                     err_o
);
    localparam int VEC_W   = N_FEAT * FEAT_W;
    localparam int N_ENTRY = 1 << IDX_W;

    logic             load;
    logic [IDX_W-1:0] map_leaf;
    logic             map_cfg;

    cls_vec_buf #(.W(VEC_W)) u_vbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .data_i (vec_i),
        .data_o (eng_vec_o)
    );

    cls_leaf_map #(.IDX_W(IDX_W), .DEPTH(N_ENTRY)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (map_we_i),
        .waddr_i (map_addr_i),
        .wdata_i (map_leaf_i),
        .raddr_i (eng_win_i),
        .rdata_o (map_leaf),
        .rcfg_o  (map_cfg)
    );

    cls_tree_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .tree_i       (tree_i),
        .root_sel_i   (root_sel_i),
        .eng_done_i   (eng_done_i),
        .eng_win_i    (eng_win_i),
        .map_leaf_i   (map_leaf),
        .map_cfg_i    (map_cfg),
        .load_o       (load),
        .busy_o       (busy_o),
        .eng_start_o  (eng_start_o),
        .eng_struct_o (eng_struct_o),
        .done_o       (done_o),
        .super_o      (super_o),
        .class_o      (class_o),
        .leaf_ran_o   (leaf_ran_o),
        .err_o        (err_o)
    );
endmodule

// File: rtl/cls_tree_seq_chk.sv
module cls_tree_seq_chk #(
    parameter int IDX_W = 6,
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [IDX_W-1:0] root_sel_i,
    input logic             busy_o,
    input logic             eng_start_o,
    input logic [IDX_W-1:0] eng_struct_o,
    input logic [VEC_W-1:0] eng_vec_o,
    input logic             done_o,
    input logic             leaf_ran_o,
    input logic             err_o
);
    AST_ROOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && eng_start_o && eng_struct_o == $past(root_sel_i))); // R2
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start_o |=> !eng_start_o); // R2
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start_o |-> busy_o); // R3
    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(eng_vec_o)); // R4
    AST_STRUCT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !eng_start_o) |-> $stable(eng_struct_o)); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_ERR_NO_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> !leaf_ran_o); // R8
endmodule

bind cls_tree_seq cls_tree_seq_chk #(.IDX_W(IDX_W), .VEC_W(N_FEAT*FEAT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .root_sel_i   (root_sel_i),
    .busy_o       (busy_o),
    .eng_start_o  (eng_start_o),
    .eng_struct_o (eng_struct_o),
    .eng_vec_o    (eng_vec_o),
    .done_o       (done_o),
    .leaf_ran_o   (leaf_ran_o),
    .err_o        (err_o)
);

// File: tb/cls_tree_seq_tb.sv
`timescale 1ns/1ps
module cls_tree_seq_tb;
    localparam int IDX_W  = 6;
    localparam int N_FEAT = 16;
    localparam int FEAT_W = 8;
    localparam int VEC_W  = N_FEAT * FEAT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             tree_i = 1'b0;
    logic [IDX_W-1:0] root_sel_i = '0;
    logic [VEC_W-1:0] vec_i = '0;
    logic             busy_o;
    logic             map_we_i = 1'b0;
    logic [IDX_W-1:0] map_addr_i = '0;
    logic [IDX_W-1:0] map_leaf_i = '0;
    logic             eng_start_o;
    logic [IDX_W-1:0] eng_struct_o;
    logic [VEC_W-1:0] eng_vec_o;
    logic             eng_done_i;
    logic [IDX_W-1:0] eng_win_i;
    logic             done_o;
    logic [IDX_W-1:0] super_o;
    logic [IDX_W-1:0] class_o;
    logic             leaf_ran_o;
    logic             err_o;

    always #2.5 clk = ~clk;

    cls_tree_seq #(.IDX_W(IDX_W), .N_FEAT(N_FEAT), .FEAT_W(FEAT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tree_i(tree_i),
        .root_sel_i(root_sel_i), .vec_i(vec_i), .busy_o(busy_o),
        .map_we_i(map_we_i), .map_addr_i(map_addr_i), .map_leaf_i(map_leaf_i),
        .eng_start_o(eng_start_o), .eng_struct_o(eng_struct_o), .eng_vec_o(eng_vec_o),
        .eng_done_i(eng_done_i), .eng_win_i(eng_win_i), .done_o(done_o),
        .super_o(super_o), .class_o(class_o), .leaf_ran_o(leaf_ran_o), .err_o(err_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // engine model state
    logic             mdl_done = 1'b0;
    logic             spur_done = 1'b0;
    logic [IDX_W-1:0] mdl_win = '0;
    logic [IDX_W-1:0] rwin = '0, lwin = '0;
    logic [VEC_W-1:0] exp_vec = '0;
    int  lat = 1, cd = 0, cyc = 0, n_start = 0;
    bit  pend = 0, pend_root = 0, vec_bad = 0, busy_at_done = 0;
    int  root_done_cyc = -10, leaf_done_cyc = -10, leaf_start_cyc = -10, done_cyc = -10;
    logic [IDX_W-1:0] leaf_struct = '0;

    assign eng_done_i = mdl_done | spur_done;
    assign eng_win_i  = mdl_win;

    always @(negedge clk) begin
        cyc = cyc + 1;
        mdl_done = 1'b0;
        if (pend) begin
            if (cd == 0) begin
                mdl_done = 1'b1;
                mdl_win  = pend_root ? rwin : lwin;
                if (pend_root) root_done_cyc = cyc; else leaf_done_cyc = cyc;
                if (eng_vec_o !== exp_vec) vec_bad = 1;
                pend = 0;
            end else begin
                cd = cd - 1;
            end
        end
        if (eng_start_o) begin
            n_start   = n_start + 1;
            pend      = 1;
            cd        = lat;
            pend_root = (n_start == 1);
            if (!pend_root) begin
                leaf_struct    = eng_struct_o;
                leaf_start_cyc = cyc;
            end
        end
        if (done_o) begin
            done_cyc     = cyc;
            busy_at_done = busy_o;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // results of the last run
    bit r_seen, r_busy1, r_start1;
    logic [IDX_W-1:0] r_struct1, r_super, r_class;
    bit r_leaf, r_err;

    task automatic map_wr(input logic [IDX_W-1:0] a, input logic [IDX_W-1:0] d);
        map_we_i = 1'b1; map_addr_i = a; map_leaf_i = d;
        @(negedge clk); #1;
        map_we_i = 1'b0;
    endtask

    task automatic run(input logic [IDX_W-1:0] rs, input bit tr, input logic [VEC_W-1:0] v,
                       input logic [IDX_W-1:0] rw, input logic [IDX_W-1:0] lw, input int l,
                       input bit poke);
        rwin = rw; lwin = lw; lat = l; exp_vec = v; n_start = 0; vec_bad = 0;
        done_cyc = -10; leaf_start_cyc = -10; leaf_struct = '0; r_seen = 0;
        vec_i = v; root_sel_i = rs; tree_i = tr; start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        vec_i = ~v;
        r_busy1 = busy_o; r_start1 = eng_start_o; r_struct1 = eng_struct_o;
        if (poke) begin
            root_sel_i = rs + 6'd1; start_i = 1'b1;
            @(negedge clk); #1;
            start_i = 1'b0;
            if (done_o) r_seen = 1;
        end
        for (int i = 0; i < 200 && !r_seen; i++) begin
            @(negedge clk); #1;
            if (done_o) r_seen = 1;
        end
        r_super = super_o; r_class = class_o; r_leaf = leaf_ran_o; r_err = err_o;
        @(negedge clk); #1;
        chk(!done_o, "R6", "done pulse width", done_o, 0);
    endtask

    task automatic t_reset();
        chk(busy_o == 0, "R1", "busy after reset", busy_o, 0);
        chk(done_o == 0, "R1", "done after reset", done_o, 0);
        chk(eng_start_o == 0, "R1", "eng_start after reset", eng_start_o, 0);
    endtask

    task automatic t_unconfigured();
        run(6'd5, 1'b1, {8{16'hA5C3}}, 6'd3, 6'd0, 2, 1'b0);
        chk(r_seen, "R8", "done seen", r_seen, 1);
        chk(r_err == 1, "R8", "err for empty entry (R1 table clear)", r_err, 1);
        chk(r_leaf == 0, "R8", "leaf_ran", r_leaf, 0);
        chk(n_start == 1, "R8", "engine starts", n_start, 1);
        chk(r_class == 6'd3, "R8", "class", r_class, 3);
    endtask

    task automatic t_flat();
        run(6'd7, 1'b0, {4{32'h1234_5678}}, 6'd9, 6'd0, 1, 1'b0);
        chk(r_err == 0, "R9", "err in flat mode", r_err, 0);
        chk(r_leaf == 0, "R9", "leaf_ran", r_leaf, 0);
        chk(r_class == 6'd9, "R9", "class", r_class, 9);
        chk(n_start == 1, "R9", "engine starts", n_start, 1);
    endtask

    task automatic t_leaf();
        map_wr(6'd3, 6'd12);
        map_wr(6'd9, 6'd63);
        run(6'd5, 1'b1, {16{8'h3C}} ^ 128'h0F, 6'd3, 6'd41, 3, 1'b0);
        chk(r_busy1 == 1, "R2", "busy after accept", r_busy1, 1);
        chk(r_start1 == 1, "R2", "root start pulse", r_start1, 1);
        chk(r_struct1 == 6'd5, "R2", "root struct", r_struct1, 5);
        chk(n_start == 2, "R5", "engine starts", n_start, 2);
        chk(leaf_struct == 6'd12, "R5", "leaf struct (R11 write)", leaf_struct, 12);
        chk(leaf_start_cyc - root_done_cyc == 1, "R5", "leaf start gap", leaf_start_cyc - root_done_cyc, 1);
        chk(done_cyc - leaf_done_cyc == 1, "R6", "done gap", done_cyc - leaf_done_cyc, 1);
        chk(busy_at_done == 0, "R6", "busy at done", busy_at_done, 0);
        chk(r_super == 6'd3, "R6", "super", r_super, 3);
        chk(r_class == 6'd41, "R6", "class", r_class, 41);
        chk(r_leaf == 1 && r_err == 0, "R6", "leaf_ran/err", {r_leaf, r_err}, 2);
        chk(vec_bad == 0, "R4", "vector held through both passes", vec_bad, 0);
    endtask

    task automatic t_noleaf();
        run(6'd2, 1'b1, {8{16'h0FF0}}, 6'd9, 6'd20, 2, 1'b0);
        chk(n_start == 1, "R7", "engine starts", n_start, 1);
        chk(done_cyc - root_done_cyc == 1, "R7", "done gap", done_cyc - root_done_cyc, 1);
        chk(r_class == 6'd9 && r_leaf == 0 && r_err == 0, "R7", "class/leaf/err", r_class, 9);
    endtask

    task automatic t_busy_start();
        run(6'd5, 1'b1, {4{32'hDEAD_BEEF}}, 6'd3, 6'd17, 4, 1'b1);
        chk(n_start == 2, "R3", "starts with start while busy", n_start, 2);
        chk(r_super == 6'd3 && r_class == 6'd17, "R3", "result unchanged", r_class, 17);
        chk(vec_bad == 0, "R4", "vector held", vec_bad, 0);
    endtask

    task automatic t_rewrite();
        map_wr(6'd3, 6'd30);
        run(6'd1, 1'b1, {2{64'h0123_4567_89AB_CDEF}}, 6'd3, 6'd8, 0, 1'b0);
        chk(leaf_struct == 6'd30, "R11", "rewritten leaf struct", leaf_struct, 30);
        chk(r_class == 6'd8 && r_leaf == 1, "R11", "class after rewrite", r_class, 8);
    endtask

    task automatic t_spurious();
        bit bad = 0;
        spur_done = 1'b1;
        @(negedge clk); #1;
        spur_done = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            if (done_o || busy_o) bad = 1;
        end
        chk(!bad, "R10", "idle done ignored", bad, 0);
        run(6'd5, 1'b1, {16{8'h77}}, 6'd3, 6'd50, 1, 1'b0);
        chk(r_class == 6'd50 && r_leaf == 1, "R10", "next run after spurious done", r_class, 50);
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_unconfigured();
        t_flat();
        t_leaf();
        t_noleaf();
        t_busy_start();
        t_rewrite();
        t_spurious();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule